// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects single-cycle interrupt requests from eleven sources: an upstream bus-reset detector, a fast and a slow periodic timer, five USB endpoint engines, a two-wire serial controller, a hub status monitor and the general-purpose pins. Each request sets its own pending flop. A pending flop stays set whether or not its source is enabled, and it is cleared only when the CPU services that source.

Two mask registers gate the pending bits. One holds an enable bit for each non-endpoint source. The other holds an enable bit for each endpoint. A single interrupt-enable flag gates the whole block. When that flag is set and at least one enabled source is pending, the block raises its interrupt line. It also presents a 14-bit program address, taken from a fixed table of two-byte slots. Slot zero is the reset entry, so source positions start at slot one.

When the CPU accepts the vector, it pulses the acknowledge input. That clears the pending flop of the presented source and drops the interrupt-enable flag. Firmware sets the flag again when it is ready for the next interrupt.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, both mask registers, the interrupt-enable flag and every pending flop are zero. irq_o stays low even when requests then arrive and the flag is set, until a mask bit is written.
- R2: A one-cycle pulse on req_i[n] sets pending bit n at the next clock edge. The bit holds through any number of idle cycles until that source is serviced.
- R3: Each bit of gen_en_d_i enables one general source: bit 0 bus reset, bit 1 fast timer, bit 2 slow timer, bit 3 serial, bit 4 hub, bit 5 GPIO. The value is written when gen_en_we_i is high at a clock edge.
- R4: Bit k of ep_en_d_i enables endpoint k, which is req_i[3+k]. The value is written when ep_en_we_i is high at a clock edge.
- R5: irq_o is high only while gie_o is high. gie_set_i sets gie_o at the next edge, unless a vector is taken in that same cycle.
- R6: The req_i bit order is: bus reset 0, fast timer 1, slow timer 2, endpoints 0..4 at 3..7, serial 8, hub 9, GPIO 10. The vector for req_i[n] is 2*(n+1), which gives 0x02 for bus reset and 0x16 for GPIO.
- R7: When several enabled sources are pending, vec_o selects the one with the lowest vector address.
- R8: When ack_i is high at an edge while irq_o is high, the presented source's pending bit and gie_o are cleared at that edge. All other pending bits are kept.
- R9: ack_i while irq_o is low changes no pending bit.
- R10: A request that arrives in the same cycle as the acknowledge of its own source leaves that source pending.
- R11: A request from a masked source is still latched. It raises irq_o as soon as its mask bit and gie_o are set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 11 | Request pulses, one per source, in the order of R6 |
| gen_en_we_i | input | 1 | Write strobe for the general mask |
| gen_en_d_i | input | 6 | New general mask value |
| ep_en_we_i | input | 1 | Write strobe for the endpoint mask |
| ep_en_d_i | input | 5 | New endpoint mask value |
| gie_set_i | input | 1 | Sets the interrupt-enable flag |
| ack_i | input | 1 | CPU accepts the presented vector |
| irq_o | output | 1 | Interrupt request to the CPU |
| vec_o | output | 14 | Vector address of the winning source |
| gie_o | output | 1 | Interrupt-enable flag |

## Verification
The assertions assume that ack_i is meaningful only in a cycle where irq_o is high, and that the CPU treats an acknowledge sampled in any other cycle as no acknowledge. The bench asserts ack_i for exactly one cycle at a time, drives every input just after a falling edge, and performs only one kind of action per cycle. The one exception is the deliberate same-cycle request and acknowledge case. Request pulses are always exactly one cycle wide, which matches the pulse interface that the latching assertion expects.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int NUM_EP      = 5;
  localparam int SRC_BUSRST  = 0;
  localparam int SRC_TMR_F   = 1;
  localparam int SRC_TMR_S   = 2;
  localparam int SRC_EP_BASE = 3;
  localparam int SRC_SERIAL  = SRC_EP_BASE + NUM_EP;
  localparam int SRC_HUB     = SRC_SERIAL + 1;
  localparam int SRC_GPIO    = SRC_HUB + 1;
  localparam int NUM_SRC     = SRC_GPIO + 1;
  localparam int NUM_GEN     = NUM_SRC - NUM_EP;
  localparam int VEC_AW      = 14;

  function automatic bit is_ep(input int src);
    return (src >= SRC_EP_BASE) && (src < SRC_EP_BASE + NUM_EP);
  endfunction

  // bit in the general mask that controls a non-endpoint source
  function automatic int gen_bit(input int src);
    return (src < SRC_EP_BASE) ? src : src - NUM_EP;
  endfunction
endpackage

// File: rtl/irqv_pend.sv
module irqv_pend #(
  parameter int N = 11
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] pend_q;

  // set beats clear so a fresh request is never lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_i) | set_i;
  end

  assign pend_o = pend_q;

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R2 R10
    req_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> pend_q[i]);
    // R2
    pend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!set_i[i] && !clr_i[i]) |=> $stable(pend_q[i]));
  end
endmodule

// File: rtl/irqv_mask.sv
module irqv_mask
  import irqv_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               gen_we_i,
  input  logic [NUM_GEN-1:0] gen_d_i,
  input  logic               ep_we_i,
  input  logic [NUM_EP-1:0]  ep_d_i,
  input  logic               gie_set_i,
  input  logic               gie_clr_i,
  output logic [NUM_SRC-1:0] en_o,
  output logic               gie_o
);
  logic [NUM_GEN-1:0] gen_q;
  logic [NUM_EP-1:0]  ep_q;
  logic               gie_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gen_q <= '0;
      ep_q  <= '0;
    end else begin
      if (gen_we_i) gen_q <= gen_d_i;
      if (ep_we_i)  ep_q  <= ep_d_i;
    end
  end

  // taking a vector overrides a same-cycle set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        gie_q <= 1'b0;
    else if (gie_clr_i) gie_q <= 1'b0;
    else if (gie_set_i) gie_q <= 1'b1;
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_map
    if (is_ep(s)) begin : g_ep
      assign en_o[s] = ep_q[s - SRC_EP_BASE];
    end else begin : g_gen
      assign en_o[s] = gen_q[gen_bit(s)];
    end
  end

  assign gie_o = gie_q;

  // R8
  gie_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gie_clr_i |=> !gie_q);
  // R5
  gie_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gie_set_i && !gie_clr_i) |=> gie_q);
endmodule

// File: rtl/irqv_prio.sv
module irqv_prio #(
  parameter int N  = 11,
  parameter int AW = 14
) (
  input  logic [N-1:0]  act_i,
  output logic [N-1:0]  grant_o,
  output logic          any_o,
  output logic [AW-1:0] vec_o
);
  logic [AW-1:0] idx;

  // lowest index wins: scan from the top down
  always_comb begin
    grant_o = '0;
    idx     = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (act_i[i]) begin
        grant_o = '0;
        grant_o[i] = 1'b1;
        idx = AW'(i);
      end
    end
  end

  assign any_o = |act_i;
  // slot zero is the reset entry, two bytes per slot
  assign vec_o = any_o ? ((idx + AW'(1)) << 1) : '0;
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqv_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [10:0]        req_i,
  input  logic               gen_en_we_i,
  input  logic [5:0]         gen_en_d_i,
  input  logic               ep_en_we_i,
  input  logic [4:0]         ep_en_d_i,
  input  logic               gie_set_i,
  input  logic               ack_i,
  output logic               irq_o,
  output logic [13:0]        vec_o,
  output logic               gie_o
);
  logic [NUM_SRC-1:0] pend, en, act, grant, clr;
  logic               any, take;

  irqv_pend #(.N(NUM_SRC)) u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (req_i),
    .clr_i  (clr),
    .pend_o (pend)
  );

  irqv_mask u_mask (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .gen_we_i  (gen_en_we_i),
    .gen_d_i   (gen_en_d_i),
    .ep_we_i   (ep_en_we_i),
    .ep_d_i    (ep_en_d_i),
    .gie_set_i (gie_set_i),
    .gie_clr_i (take),
    .en_o      (en),
    .gie_o     (gie_o)
  );

  assign act = pend & en;

  irqv_prio #(.N(NUM_SRC), .AW(VEC_AW)) u_prio (
    .act_i   (act),
    .grant_o (grant),
    .any_o   (any),
    .vec_o   (vec_o)
  );

  assign irq_o = gie_o & any;
  assign take  = ack_i & irq_o;
  assign clr   = take ? grant : '0;

  // R5
  irq_gie_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> gie_o);
  // R7
  grant_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant) && (any == (grant != '0)));
  // R7
  lowest_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any |-> ((act & (grant - NUM_SRC'(1))) == '0));
  // R6
  vec_even_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (vec_o[0] == 1'b0 && vec_o != '0));
  // R8 R10
  ack_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> ((pend & $past(grant & ~req_i)) == '0));
  // R9
  idle_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !irq_o) |=> ((pend & $past(pend)) == $past(pend)));
endmodule

// File: tb/tb_irq_vector_ctrl.sv
module tb_irq_vector_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [10:0] req = '0;
  logic        gen_we = 1'b0, ep_we = 1'b0, gie_set = 1'b0, ack = 1'b0;
  logic [5:0]  gen_d = '0;
  logic [4:0]  ep_d = '0;
  logic        irq, gie;
  logic [13:0] vec;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  irq_vector_ctrl dut (
    .clk_i (clk), .rst_ni (rst_ni), .req_i (req),
    .gen_en_we_i (gen_we), .gen_en_d_i (gen_d),
    .ep_en_we_i (ep_we), .ep_en_d_i (ep_d),
    .gie_set_i (gie_set), .ack_i (ack),
    .irq_o (irq), .vec_o (vec), .gie_o (gie)
  );

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic post(input logic [10:0] m);
    req = m; step(); req = '0;
  endtask

  task automatic set_en(input logic [5:0] g, input logic [4:0] e);
    gen_we = 1'b1; gen_d = g; ep_we = 1'b1; ep_d = e;
    step();
    gen_we = 1'b0; ep_we = 1'b0;
  endtask

  task automatic gie_on();
    gie_set = 1'b1; step(); gie_set = 1'b0;
  endtask

  task automatic do_ack();
    ack = 1'b1; step(); ack = 1'b0;
  endtask

  task automatic drain();
    set_en('1, '1);
    for (int k = 0; k < 16; k++) begin
      gie_on();
      if (!irq) break;
      do_ack();
    end
    set_en('0, '0);
  endtask

  task automatic t_reset();
    chk("R1 irq after reset", irq, 0);
    chk("R1 gie after reset", gie, 0);
    post('1);
    gie_on();
    chk("R1 irq with masks clear", irq, 0);
    set_en('1, '1);
    chk("R11 masked requests kept", irq, 1);
    chk("R7 lowest wins", vec, 2);
  endtask

  task automatic t_order();
    for (int k = 0; k < 11; k++) begin
      chk("R6 vector order", vec, (k + 1) * 2);
      do_ack();
      chk("R8 gie cleared on take", gie, 0);
      gie_on();
    end
    chk("R8 all serviced", irq, 0);
  endtask

  task automatic t_masks();
    set_en('0, '0);
    post('1);
    chk("R1 mask zero blocks", irq, 0);
    set_en(6'b010000, '0);
    chk("R3 hub bit", vec, 20);
    set_en('0, 5'b00100);
    chk("R4 endpoint 2", vec, 12);
    set_en(6'b100000, '0);
    chk("R3 gpio bit", vec, 22);
    set_en(6'b000100, '0);
    chk("R3 slow timer bit", vec, 6);
    drain();
  endtask

  task automatic t_gie();
    set_en('1, '1);
    post(11'b10);
    chk("R5 irq with gie", irq, 1);
    do_ack();
    post(11'b100);
    chk("R5 gie off blocks", irq, 0);
    gie_on();
    chk("R5 gie set raises", irq, 1);
    chk("R5 vector", vec, 6);
    do_ack();
  endtask

  task automatic t_idle_ack();
    post(11'h400);
    do_ack();
    gie_on();
    chk("R9 idle ack ignored", irq, 1);
    chk("R9 vector", vec, 22);
    do_ack();
  endtask

  task automatic t_same();
    post(11'h080);
    gie_on();
    chk("R10 ep4 vector", vec, 16);
    req = 11'h080; ack = 1'b1;
    step();
    req = '0; ack = 1'b0;
    chk("R8 gie cleared", gie, 0);
    gie_on();
    chk("R10 still pending", irq, 1);
    chk("R10 vector", vec, 16);
    do_ack();
    gie_on();
    chk("R8 cleared after plain ack", irq, 0);
  endtask

  task automatic t_persist();
    post(11'h100);
    repeat (5) step();
    chk("R2 held pending", irq, 1);
    chk("R2 serial vector", vec, 18);
    do_ack();
    gie_on();
    chk("R2 cleared once served", irq, 0);
  endtask

  initial begin
    step(); step();
    rst_ni = 1'b1;
    step();
    t_reset();
    t_order();
    t_masks();
    t_gie();
    t_idle_ack();
    t_same();
    t_persist();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule